// File: doc/BRIEF.md
# Multi-channel periodic interrupt timer

This block holds a bank of independent down-counting timer channels behind a small register port. The port has an address, write data and a write strobe, and returns read data in the same cycle. Software gives each channel a load value and then enables the channel. The channel counts down to zero, sets its expiry flag, reloads from the load value and keeps running. A channel raises its interrupt line while its flag is set and its interrupt enable is on. Software clears the flag by writing a one to it.

Writing a new load value while a channel runs does not restart the channel. The new value first takes effect when the current period ends. To start a fresh period at once, software clears the channel's enable bit and then sets it again. A module-wide freeze bit, combined with an external debug-halt input, stops every running counter in place. This lets a halted system inspect the counters without them moving.

Top module: `ptimer_bank`

## Requirements
- R1: After reset every register reads 0 and every interrupt output is low.
- R2: In the cycle after a channel's enable bit goes from 0 to 1, the current-value register shows the load value. From the next cycle on it falls by one per cycle.
- R3: An enabled, unfrozen channel whose counter is 0 reloads the load value at the next edge and sets bit 0 of its flag register at the same edge. A load value L therefore gives a period of L+1 cycles.
- R4: Writing the load register of a running channel leaves the ongoing count untouched. The new value is used at the next reload.
- R5: Writing the enable bit to 0 and then to 1 in the next cycle makes the counter show the current load value one cycle after the second write.
- R6: While a channel is disabled, its counter holds its last value, and the current-value register returns that held value.
- R7: When bit 0 of the module control register (address 0x000, the freeze bit) is 1 and dbg_halt_i is high, no running counter changes. Either condition alone has no effect. A channel start still loads the load value during a freeze.
- R8: Writing 1 to bit 0 of a channel's flag register (offset +0xC) clears the flag, and writing 0 leaves it unchanged. When a clear and an expiry fall in the same cycle, the flag stays set.
- R9: irq_o[n] is high exactly while channel n's flag is set and bit 1 of its control register (the interrupt enable) is 1.
- R10: Channel n occupies addresses 0x100 + 0x10*n, for n = 0 to 3. The load value sits at +0x0 and the current value at +0x4; the current value is read-only, and writes to it are ignored. The control register sits at +0x8, with bit 0 as the enable and bit 1 as the interrupt enable. The flag register sits at +0xC.
- R11: Any address outside the registers above, including misaligned ones, reads as 0, and writes to it change no state.
- R12: With a load value of 0, an enabled channel expires on every cycle after its start cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dbg_halt_i | input | 1 | Debug halt; freezes counters when the freeze bit is set |
| addr_i | input | ADDR_W (12) | Register byte address |
| wdata_i | input | DATA_W (32) | Write data |
| we_i | input | 1 | Write strobe, takes effect at the clock edge |
| rdata_o | output | DATA_W (32) | Read data for addr_i, same cycle |
| irq_o | output | NUM_CH (4) | Per-channel interrupt |

## Verification
The bench builds the block with its default sizes: four channels, 32-bit counters and a 12-bit address. With four channels every channel window can be reached, and so can the first address past the last window. The bench keeps load values small (0 to 12 in the random phase, plus 5, 100 and 1000 in the directed tests). Many periods therefore expire, and many flag clears collide with expiries, within a short run. The single load value of 0 exercises the every-cycle expiry case.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int unsigned MCR_ADDR    = 'h000;
  localparam int unsigned CH_BASE     = 'h100;
  localparam int unsigned CH_STRIDE   = 'h10;
  localparam int unsigned OFF_LOAD    = 'h0;
  localparam int unsigned OFF_CUR     = 'h4;
  localparam int unsigned OFF_CTRL    = 'h8;
  localparam int unsigned OFF_FLAG    = 'hC;
  localparam int unsigned CTRL_EN_BIT = 0;
  localparam int unsigned CTRL_IE_BIT = 1;
  localparam int unsigned MCR_FRZ_BIT = 0;
  localparam int unsigned FLAG_BIT    = 0;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MCR,
    SEL_LOAD,
    SEL_CUR,
    SEL_CTRL,
    SEL_FLAG
  } reg_sel_e;
endpackage

// File: rtl/ptimer_decode.sv
module ptimer_decode
  import ptimer_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  output reg_sel_e            sel_o,
  output logic [CH_IDX_W-1:0] ch_o
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(CH_BASE);
  localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(NUM_CH * CH_STRIDE);
  localparam logic [ADDR_W-1:0] MCR_A  = ADDR_W'(MCR_ADDR);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-5:0] win_idx;

  assign off     = addr_i - BASE_A;
  assign win_idx = off[ADDR_W-1:4];

  always_comb begin
    sel_o = SEL_NONE;
    ch_o  = '0;
    if (addr_i == MCR_A) begin
      sel_o = SEL_MCR;
    end else if (addr_i >= BASE_A && off < SPAN_A && off[1:0] == 2'b00) begin
      ch_o = CH_IDX_W'(win_idx);
      unique case (off[3:2])
        2'(OFF_LOAD >> 2): sel_o = SEL_LOAD;
        2'(OFF_CUR >> 2):  sel_o = SEL_CUR;
        2'(OFF_CTRL >> 2): sel_o = SEL_CTRL;
        default:           sel_o = SEL_FLAG;
      endcase
    end
  end
endmodule

// File: rtl/ptimer_chan.sv
module ptimer_chan #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frozen_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             ctrl_we_i,
  input  logic             en_val_i,
  input  logic             ie_val_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             ie_o,
  output logic             flag_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] load_q, cnt_q;
  logic             en_q, en_d_q, ie_q, flag_q;
  logic             start, tick, expire;

  assign start  = en_q & ~en_d_q;
  assign tick   = en_q & en_d_q & ~frozen_i;
  assign expire = tick & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
    end else if (load_we_i) begin
      load_q <= load_val_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= 1'b0;
      en_d_q <= 1'b0;
    end else begin
      en_d_q <= en_q;
      if (ctrl_we_i) begin
        en_q <= en_val_i;
        ie_q <= ie_val_i;
      end
    end
  end

  // start and expiry both take the load value; new load seen only here
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (start || expire) begin
      cnt_q <= load_q;
    end else if (tick) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // expiry wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
    end else if (expire) begin
      flag_q <= 1'b1;
    end else if (flag_clr_i) begin
      flag_q <= 1'b0;
    end
  end

  assign load_o = load_q;
  assign cnt_o  = cnt_q;
  assign en_o   = en_q;
  assign ie_o   = ie_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/ptimer_bank.sv
module ptimer_bank
  import ptimer_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dbg_halt_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  reg_sel_e                       sel;
  logic [CH_IDX_W-1:0]            ch_sel;
  logic                           frz_q;
  logic                           frozen;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_load;
  logic [NUM_CH-1:0][CNT_W-1:0]   ch_cnt;
  logic [NUM_CH-1:0]              ch_en, ch_ie, ch_flag;

  ptimer_decode #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH)
  ) decode_i (
    .addr_i (addr_i),
    .sel_o  (sel),
    .ch_o   (ch_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_q <= 1'b0;
    end else if (we_i && sel == SEL_MCR) begin
      frz_q <= wdata_i[MCR_FRZ_BIT];
    end
  end

  assign frozen = frz_q & dbg_halt_i;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (ch_sel == CH_IDX_W'(g));

    ptimer_chan #(
      .CNT_W (CNT_W)
    ) chan_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .frozen_i   (frozen),
      .load_we_i  (we_i && hit && sel == SEL_LOAD),
      .load_val_i (wdata_i[CNT_W-1:0]),
      .ctrl_we_i  (we_i && hit && sel == SEL_CTRL),
      .en_val_i   (wdata_i[CTRL_EN_BIT]),
      .ie_val_i   (wdata_i[CTRL_IE_BIT]),
      .flag_clr_i (we_i && hit && sel == SEL_FLAG && wdata_i[FLAG_BIT]),
      .load_o     (ch_load[g]),
      .cnt_o      (ch_cnt[g]),
      .en_o       (ch_en[g]),
      .ie_o       (ch_ie[g]),
      .flag_o     (ch_flag[g]),
      .irq_o      (irq_o[g])
    );
  end

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_MCR:  rdata_o[MCR_FRZ_BIT] = frz_q;
      SEL_LOAD: rdata_o[CNT_W-1:0]   = ch_load[ch_sel];
      SEL_CUR:  rdata_o[CNT_W-1:0]   = ch_cnt[ch_sel];
      SEL_CTRL: begin
        rdata_o[CTRL_EN_BIT] = ch_en[ch_sel];
        rdata_o[CTRL_IE_BIT] = ch_ie[ch_sel];
      end
      SEL_FLAG: rdata_o[FLAG_BIT] = ch_flag[ch_sel];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ptimer_bank_chk.sv
module ptimer_bank_chk #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CNT_W  = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           dbg_halt_i,
  input logic                           frz_i,
  input logic [NUM_CH-1:0]              en_i,
  input logic [NUM_CH-1:0]              flag_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]   load_i,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cnt_i
);
  logic [NUM_CH-1:0] en_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_prev <= '0;
    else         en_prev <= en_i;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    logic run;
    assign run = en_i[g] & en_prev[g] & ~(frz_i & dbg_halt_i);

    // R2
    start_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i[g] && !en_prev[g]) |=> cnt_i[g] == $past(load_i[g]));

    // R2
    step_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt_i[g] != '0) |=> (cnt_i[g] + 1'b1) == $past(cnt_i[g]));

    // R3
    reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run && cnt_i[g] == '0) |=> (cnt_i[g] == $past(load_i[g]) && flag_i[g]));

    // R3
    flag_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_i[g]) |-> $past(cnt_i[g]) == '0);

    // R6
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |=> $stable(cnt_i[g]));

    // R7
    freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (frz_i && dbg_halt_i && en_i[g] && en_prev[g]) |=> $stable(cnt_i[g]));
  end
endmodule

bind ptimer_bank ptimer_bank_chk #(
  .NUM_CH (NUM_CH),
  .CNT_W  (CNT_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dbg_halt_i (dbg_halt_i),
  .frz_i      (frz_q),
  .en_i       (ch_en),
  .flag_i     (ch_flag),
  .load_i     (ch_load),
  .cnt_i      (ch_cnt)
);

// File: tb/ptimer_bank_tb_top.sv
`timescale 1ns/1ps
module ptimer_bank_tb_top;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbg = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic [3:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptimer_bank #(.NUM_CH(4), .CNT_W(32), .ADDR_W(12), .DATA_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dbg_halt_i(dbg), .addr_i(addr),
    .wdata_i(wdata), .we_i(we), .rdata_o(rdata), .irq_o(irq));

  // behavioural reference
  logic [31:0] m_load [NCH];
  logic [31:0] m_cnt  [NCH];
  bit m_en [NCH], m_en_d [NCH], m_ie [NCH], m_flag [NCH], m_ex [NCH], m_clr [NCH];
  bit m_frz;

  function automatic int win_ch(input logic [11:0] a);
    if (a >= 12'h100 && a < 12'h140 && a[1:0] == 2'b00) return (int'(a) - 256) / 16;
    return -1;
  endfunction

  function automatic logic [31:0] mread(input logic [11:0] a);
    int c;
    if (a == 12'h000) return {31'b0, m_frz};
    c = win_ch(a);
    if (c < 0) return 32'h0;
    case (a[3:2])
      2'd0: return m_load[c];
      2'd1: return m_cnt[c];
      2'd2: return {30'b0, m_ie[c], m_en[c]};
      default: return {31'b0, m_flag[c]};
    endcase
  endfunction

  function automatic logic [31:0] mirq();
    logic [31:0] v = '0;
    for (int c = 0; c < NCH; c++) v[c] = m_flag[c] & m_ie[c];
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_frz = 0;
      for (int c = 0; c < NCH; c++) begin
        m_load[c] = 0; m_cnt[c] = 0; m_en[c] = 0; m_en_d[c] = 0;
        m_ie[c] = 0; m_flag[c] = 0; m_ex[c] = 0; m_clr[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit run;
        run = m_en[c] && m_en_d[c] && !(m_frz && dbg);
        m_ex[c] = run && (m_cnt[c] == 0);
        m_clr[c] = 0;
        if ((m_en[c] && !m_en_d[c]) || m_ex[c]) m_cnt[c] = m_load[c];
        else if (run) m_cnt[c] = m_cnt[c] - 1;
        m_en_d[c] = m_en[c];
      end
      if (we) begin
        int c;
        c = win_ch(addr);
        if (addr == 12'h000) m_frz = wdata[0];
        else if (c >= 0) begin
          case (addr[3:2])
            2'd0: m_load[c] = wdata;
            2'd2: begin m_en[c] = wdata[0]; m_ie[c] = wdata[1]; end
            2'd3: m_clr[c] = wdata[0];
            default: ;
          endcase
        end
      end
      for (int c = 0; c < NCH; c++) begin
        if (m_clr[c]) m_flag[c] = 0;
        if (m_ex[c]) m_flag[c] = 1;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the reference
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check("R9 irq vs model", {28'b0, irq}, mirq());
      check("R10 rdata vs model", rdata, mread(addr));
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; #1;
    check(tag, rdata, e);
  endtask

  task automatic rd_get(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1;
    v = rdata;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(12'h000, 0, "R1 freeze reg");
    for (int c = 0; c < NCH; c++) begin
      for (int r = 0; r < 4; r++) rd_chk(12'(256 + 16 * c + 4 * r), 0, "R1 channel reg");
    end
    check("R1 irq low", {28'b0, irq}, 0);

    // R11 unmapped
    wr(12'h004, 32'hFFFF_FFFF);
    wr(12'h140, 32'h0000_0003);
    wr(12'h102, 32'h0000_0007);
    rd_chk(12'h004, 0, "R11 unmapped read");
    rd_chk(12'h140, 0, "R11 past last window");
    rd_chk(12'h102, 0, "R11 misaligned");
    rd_chk(12'h800, 0, "R11 high address");
    rd_chk(12'h000, 0, "R11 freeze untouched");
    rd_chk(12'h100, 0, "R11 load untouched");

    // R2 / R3 channel 0, load 5
    wr(12'h100, 5);
    wr(12'h108, 3);
    rd_chk(12'h104, 0, "R2 not yet loaded");
    rd_chk(12'h104, 5, "R2 start load");
    for (int k = 4; k >= 0; k--) rd_chk(12'h104, 32'(k), "R2 decrement");
    rd_chk(12'h104, 5, "R3 reload");
    rd_chk(12'h10C, 1, "R3 flag set");
    check("R9 irq high", {31'b0, irq[0]}, 1);
    wr(12'h108, 1);
    @(negedge clk); #1;
    check("R9 irq masked", {31'b0, irq[0]}, 0);

    // R6 / R10 disabled channel holds, current value read-only
    wr(12'h108, 0);
    rd_get(12'h104, v);
    repeat (3) @(negedge clk);
    rd_chk(12'h104, v, "R6 hold while disabled");
    wr(12'h104, 32'h1234);
    rd_chk(12'h104, v, "R10 current value read-only");
    wr(12'h10C, 0);
    rd_chk(12'h10C, 1, "R8 write 0 keeps flag");
    wr(12'h10C, 1);
    rd_chk(12'h10C, 0, "R8 write 1 clears flag");

    // R5 restart
    wr(12'h118, 1);
    wr(12'h110, 100);
    repeat (6) @(negedge clk);
    wr(12'h118, 0);
    wr(12'h118, 1);
    @(negedge clk);
    rd_chk(12'h114, 100, "R5 restart from load");

    // R4 load write while running
    rd_get(12'h114, v);
    wr(12'h110, 3);
    rd_chk(12'h114, v - 2, "R4 count unaffected");
    rd_chk(12'h110, 3, "R4 load stored");

    // R7 freeze
    wr(12'h120, 1000);
    wr(12'h128, 1);
    wr(12'h000, 1);
    rd_get(12'h124, v);
    rd_chk(12'h124, v - 1, "R7 freeze bit alone");
    @(negedge clk); dbg = 1'b1; #1; v = rdata;
    rd_chk(12'h124, v, "R7 frozen");
    rd_chk(12'h124, v, "R7 still frozen");
    wr(12'h000, 0);
    rd_chk(12'h124, v, "R7 held through write edge");
    rd_chk(12'h124, v - 1, "R7 debug alone");
    dbg = 1'b0;

    // R12 / R8 load 0
    wr(12'h138, 3);
    repeat (3) @(negedge clk);
    rd_chk(12'h134, 0, "R12 counter at 0");
    wr(12'h13C, 1);
    rd_chk(12'h13C, 1, "R8 expiry beats clear");
    check("R12 irq", {31'b0, irq[3]}, 1);

    // random mix, reference compared every clock
    for (int i = 0; i < 3000; i++) begin
      int c, op;
      c = $urandom_range(0, NCH - 1);
      op = $urandom_range(0, 9);
      if ($urandom_range(0, 15) == 0) begin
        @(negedge clk); dbg = ~dbg;
      end
      case (op)
        0: wr(12'(256 + 16 * c), 32'($urandom_range(0, 12)));
        1: wr(12'(256 + 16 * c + 8), 32'($urandom_range(0, 3)));
        2: wr(12'(256 + 16 * c + 12), 32'($urandom_range(0, 1)));
        3: wr(12'h000, 32'($urandom_range(0, 1)));
        4: wr(12'(256 + 16 * c + 4), $urandom);
        default: rd_get(12'(256 + 16 * c + 4 * $urandom_range(0, 3)), w);
      endcase
    end

    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule